// File: doc/BRIEF.md
# Pulsed Mismatch Trip Detector

This block watches pairs of forward and reflected power samples that arrive together while a calculation-window input is high. For every sample pair it grades the reflection ratio against three programmable limits. The result is one of four levels: normal, warning, soft band or hard. A sample in the hard level raises a trip output on the next clock. That output is meant to drive the fast RF shutdown path. A soft trip is raised only when the soft condition persists inside one pulse, or recurs over several pulses in a row. While the window is open, the block also accumulates both power streams. When the window closes, it hands software the integer mean of each stream together with a one-cycle done strobe.

All limits are given in the ratio domain. Software converts a standing-wave limit into the equivalent power reflection ratio Pref/Pfwd and loads it as an unsigned fraction with `TW` fraction bits. A sample whose forward power is below a programmable floor is not graded, so the noise on the edges of a pulse cannot trip anything. Such a sample still enters the averages. Calibration to physical units is left to software.

Top module: `vswr_trip_det`

## Requirements
- R1: A sample is graded only when `calc_win` and `smp_valid` are both high and `fwd_pwr >= min_fwd`. A limit T counts as reached when rev·2^TW ≥ fwd·T. The level is hard if `hard_thr` is reached, otherwise soft if `soft_thr` is reached, otherwise warning if `warn_thr` is reached, otherwise normal. One clock after a graded sample, `warn_flag` is high exactly for the warning level and `soft_band` is high exactly for the soft level. The two flags are never high together.
- R2: `hard_trip` is high on the clock after any graded sample at the hard level, with no persistence needed. It stays high until the next window opens.
- R3: A sample taken while `calc_win` is low, or one with `fwd_pwr < min_fwd`, leaves `warn_flag`, `soft_band`, `hard_trip` and the persistence counters unchanged.
- R4: A graded sample at the soft or hard level counts as in-band. Once `run_len` (when non-zero) consecutive in-band graded samples occur in one window, `soft_trip` is high on the next clock. A graded warning or normal sample restarts the run. A skipped sample does not.
- R5: Once `pulse_lim` (when non-zero) windows in a row each contain at least one in-band sample, `soft_trip` goes high on the clock after the last of those windows closes. A window with no in-band sample restarts the count.
- R6: `soft_trip` stays high until a window closes with no in-band sample. It clears on the clock after that window closes.
- R7: When a window closes, the block computes floor(sum/count) over the valid samples taken in that window, including ungraded ones, for each power stream. It presents the results on `avg_fwd` and `avg_rev` with a one-cycle `avg_done` pulse. Only the first `MAX_SAMPLES` samples of a window are counted. An empty window gives averages of 0.
- R8: After reset, all outputs are 0.
- R9: The rising edge of `calc_win` clears `warn_flag`, `soft_band` and `hard_trip`, unless a graded sample on that same clock sets them again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| calc_win | input | 1 | Calculation window; grading and averaging only while high |
| smp_valid | input | 1 | A new forward/reflected pair is present |
| fwd_pwr | input | PW | Forward power sample, unsigned |
| rev_pwr | input | PW | Reflected power sample, unsigned |
| warn_thr | input | TW | Warning ratio limit, fraction of 2^TW |
| soft_thr | input | TW | Soft-band ratio limit, fraction of 2^TW |
| hard_thr | input | TW | Hard-trip ratio limit, fraction of 2^TW |
| min_fwd | input | PW | Forward-power floor for grading |
| run_len | input | RW | Consecutive in-band samples for soft trip; 0 disables |
| pulse_lim | input | PCW | Consecutive in-band windows for soft trip; 0 disables |
| warn_flag | output | 1 | Last graded sample was at the warning level |
| soft_band | output | 1 | Last graded sample was at the soft level |
| soft_trip | output | 1 | Persistent or recurring soft mismatch |
| hard_trip | output | 1 | Hard mismatch seen in the current window |
| avg_fwd | output | PW | Mean forward power of the last window |
| avg_rev | output | PW | Mean reflected power of the last window |
| avg_done | output | 1 | One-cycle strobe when the averages are updated |

## Verification
A fault in the grading compare shows on the level flags one clock after the sample, so each stimulus pair is checked at that point. A run or pulse counter that fails to restart shows as `soft_trip` rising one sample or one window too early. A counter that fails to count shows as `soft_trip` staying low at the exact sample or window where it must rise. Accumulator or divider faults show only when `avg_done` pulses, about `PW`+13 clocks after the window closes. The averages are therefore compared in that strobe cycle for single-sample windows, mixed windows, an empty window and a window longer than the cap.

// File: rtl/vswr_pkg.sv
package vswr_pkg;

  typedef enum logic [1:0] {
    LV_OK   = 2'd0,
    LV_WARN = 2'd1,
    LV_SOFT = 2'd2,
    LV_HARD = 2'd3
  } lvl_e;

  // Ratio test without divide or root: rev/fwd >= thr/2^frac
  function automatic logic ratio_at_least(input logic [31:0] fwd,
                                          input logic [31:0] rev,
                                          input logic [31:0] thr,
                                          input int unsigned frac);
    logic [63:0] lhs;
    logic [63:0] rhs;
    lhs = {32'd0, rev} << frac;
    rhs = {32'd0, fwd} * {32'd0, thr};
    return lhs >= rhs;
  endfunction

endpackage

// File: rtl/vswr_level_cmp.sv
module vswr_level_cmp
  import vswr_pkg::*;
#(
  parameter int PW = 16,
  parameter int TW = 8
) (
  input  logic [PW-1:0] fwd,
  input  logic [PW-1:0] rev,
  input  logic [TW-1:0] warn_thr,
  input  logic [TW-1:0] soft_thr,
  input  logic [TW-1:0] hard_thr,
  output lvl_e          lvl
);

  localparam int NLIM = 3;

  logic [TW-1:0] lim_a [NLIM];
  logic [NLIM-1:0] reach;

  assign lim_a[0] = warn_thr;
  assign lim_a[1] = soft_thr;
  assign lim_a[2] = hard_thr;

  for (genvar g = 0; g < NLIM; g++) begin : g_lim
    assign reach[g] = ratio_at_least(32'(fwd), 32'(rev), 32'(lim_a[g]), TW);
  end

  always_comb begin
    if (reach[2])      lvl = LV_HARD;
    else if (reach[1]) lvl = LV_SOFT;
    else if (reach[0]) lvl = LV_WARN;
    else               lvl = LV_OK;
  end

endmodule

// File: rtl/vswr_soft_persist.sv
module vswr_soft_persist #(
  parameter int RW  = 8,
  parameter int PCW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           eval,
  input  logic           in_band,
  input  logic           win_rise,
  input  logic           win_fall,
  input  logic [RW-1:0]  run_len,
  input  logic [PCW-1:0] pulse_lim,
  output logic           soft_trip
);

  logic [RW-1:0]  run_cnt;
  logic [PCW-1:0] pulse_cnt;
  logic           hit;

  logic [RW-1:0]  run_base;
  logic           hit_base;
  logic [RW-1:0]  run_inc;
  logic [PCW-1:0] pulse_inc;

  always_comb begin
    run_base  = win_rise ? '0 : run_cnt;
    hit_base  = win_rise ? 1'b0 : hit;
    run_inc   = (&run_base) ? run_base : run_base + 1'b1;
    pulse_inc = (&pulse_cnt) ? pulse_cnt : pulse_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt   <= '0;
      pulse_cnt <= '0;
      hit       <= 1'b0;
      soft_trip <= 1'b0;
    end else begin
      if (eval) begin
        if (in_band) begin
          run_cnt <= run_inc;
          hit     <= 1'b1;
          if (run_len != '0 && run_inc >= run_len) soft_trip <= 1'b1;
        end else begin
          run_cnt <= '0;
          hit     <= hit_base;
        end
      end else if (win_rise) begin
        run_cnt <= '0;
        hit     <= 1'b0;
      end
      if (win_fall) begin
        if (hit) begin
          pulse_cnt <= pulse_inc;
          if (pulse_lim != '0 && pulse_inc >= pulse_lim) soft_trip <= 1'b1;
        end else begin
          pulse_cnt <= '0;
          soft_trip <= 1'b0;
        end
      end
    end
  end

  // R4 / R5: a soft trip only starts from an in-band sample or a window close
  p_soft_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_trip) |-> $past(eval && in_band) || $past(win_fall));

  // R4: a graded out-of-band sample restarts the run
  p_run_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eval && !in_band |=> run_cnt == '0);

  // R6: soft trip drops only after a window without an in-band sample
  p_soft_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_trip) |-> $past(win_fall && !hit));

endmodule

// File: rtl/vswr_avg_chan.sv
module vswr_avg_chan #(
  parameter int PW          = 16,
  parameter int MAX_SAMPLES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          win_rise,
  input  logic          win_fall,
  input  logic [PW-1:0] din,
  output logic [PW-1:0] avg,
  output logic          done
);

  localparam int CNTW = $clog2(MAX_SAMPLES + 1);
  localparam int SW   = PW + CNTW;
  localparam int IW   = $clog2(SW);

  logic [SW-1:0]   sum;
  logic [CNTW-1:0] cnt;
  logic [SW-1:0]   sum_base;
  logic [CNTW-1:0] cnt_base;

  logic            busy;
  logic [IW-1:0]   idx;
  logic [SW-1:0]   dvd;
  logic [CNTW-1:0] dvs;
  logic [CNTW-1:0] rem;
  logic [SW-1:0]   quo;

  logic [CNTW:0]   trial;
  logic            qbit;
  logic [CNTW-1:0] rem_nxt;
  logic [SW-1:0]   quo_nxt;

  always_comb begin
    sum_base = win_rise ? '0 : sum;
    cnt_base = win_rise ? '0 : cnt;
    trial    = {rem, dvd[idx]};
    qbit     = trial >= {1'b0, dvs};
    rem_nxt  = qbit ? CNTW'(trial - {1'b0, dvs}) : trial[CNTW-1:0];
    quo_nxt  = {quo[SW-2:0], qbit};
  end

  // Accumulator, one per window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum <= '0;
      cnt <= '0;
    end else if (take) begin
      if (cnt_base < CNTW'(MAX_SAMPLES)) begin
        sum <= sum_base + SW'(din);
        cnt <= cnt_base + 1'b1;
      end else begin
        sum <= sum_base;
        cnt <= cnt_base;
      end
    end else if (win_rise) begin
      sum <= '0;
      cnt <= '0;
    end
  end

  // Serial restoring divider, one quotient bit per clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      dvd  <= '0;
      dvs  <= '0;
      rem  <= '0;
      quo  <= '0;
      avg  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (win_fall) begin
        busy <= 1'b1;
        idx  <= IW'(SW - 1);
        dvd  <= sum;
        dvs  <= cnt;
        rem  <= '0;
        quo  <= '0;
      end else if (busy) begin
        rem <= rem_nxt;
        quo <= quo_nxt;
        if (idx == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
          avg  <= (dvs == '0) ? '0 : quo_nxt[PW-1:0];
        end else begin
          idx <= idx - 1'b1;
        end
      end
    end
  end

  // R7: the sample count never passes the cap
  p_cnt_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNTW'(MAX_SAMPLES));

  // R7: the done strobe lasts one clock
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/vswr_trip_det.sv
module vswr_trip_det
  import vswr_pkg::*;
#(
  parameter int PW          = 16,
  parameter int TW          = 8,
  parameter int RW          = 8,
  parameter int PCW         = 8,
  parameter int MAX_SAMPLES = 4096
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           calc_win,
  input  logic           smp_valid,
  input  logic [PW-1:0]  fwd_pwr,
  input  logic [PW-1:0]  rev_pwr,
  input  logic [TW-1:0]  warn_thr,
  input  logic [TW-1:0]  soft_thr,
  input  logic [TW-1:0]  hard_thr,
  input  logic [PW-1:0]  min_fwd,
  input  logic [RW-1:0]  run_len,
  input  logic [PCW-1:0] pulse_lim,
  output logic           warn_flag,
  output logic           soft_band,
  output logic           soft_trip,
  output logic           hard_trip,
  output logic [PW-1:0]  avg_fwd,
  output logic [PW-1:0]  avg_rev,
  output logic           avg_done
);

  localparam int NCH = 2;

  logic win_q;
  logic win_rise;
  logic win_fall;
  logic take;
  logic eval;
  lvl_e lvl;
  logic in_band;

  logic [PW-1:0] din_a  [NCH];
  logic [PW-1:0] avg_a  [NCH];
  logic [NCH-1:0] done_a;

  assign win_rise = calc_win & ~win_q;
  assign win_fall = ~calc_win & win_q;
  assign take     = calc_win & smp_valid;
  assign eval     = take & (fwd_pwr >= min_fwd);
  assign in_band  = (lvl == LV_SOFT) || (lvl == LV_HARD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= calc_win;
  end

  vswr_level_cmp #(.PW(PW), .TW(TW)) u_cmp (
    .fwd      (fwd_pwr),
    .rev      (rev_pwr),
    .warn_thr (warn_thr),
    .soft_thr (soft_thr),
    .hard_thr (hard_thr),
    .lvl      (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_flag <= 1'b0;
      soft_band <= 1'b0;
      hard_trip <= 1'b0;
    end else if (eval) begin
      warn_flag <= (lvl == LV_WARN);
      soft_band <= (lvl == LV_SOFT);
      hard_trip <= (lvl == LV_HARD) | (hard_trip & ~win_rise);
    end else if (win_rise) begin
      warn_flag <= 1'b0;
      soft_band <= 1'b0;
      hard_trip <= 1'b0;
    end
  end

  vswr_soft_persist #(.RW(RW), .PCW(PCW)) u_persist (
    .clk       (clk),
    .rst_n     (rst_n),
    .eval      (eval),
    .in_band   (in_band),
    .win_rise  (win_rise),
    .win_fall  (win_fall),
    .run_len   (run_len),
    .pulse_lim (pulse_lim),
    .soft_trip (soft_trip)
  );

  assign din_a[0] = fwd_pwr;
  assign din_a[1] = rev_pwr;

  for (genvar c = 0; c < NCH; c++) begin : g_avg
    vswr_avg_chan #(.PW(PW), .MAX_SAMPLES(MAX_SAMPLES)) u_avg (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .win_rise (win_rise),
      .win_fall (win_fall),
      .din      (din_a[c]),
      .avg      (avg_a[c]),
      .done     (done_a[c])
    );
  end

  assign avg_fwd  = avg_a[0];
  assign avg_rev  = avg_a[1];
  assign avg_done = done_a[0];

  // R2: a hard sample trips on the next clock
  p_hard_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eval && lvl == LV_HARD |=> hard_trip);

  // R2: a hard trip holds until a new window opens
  p_hard_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hard_trip && !win_rise |=> hard_trip);

  // R3: ungraded cycles leave the band flags alone
  p_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !eval && !win_rise |=> $stable({warn_flag, soft_band, hard_trip}));

  // R1: warning and soft band are exclusive
  p_band_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({warn_flag, soft_band}));

  // R9: window open with no graded sample clears the flags
  p_open_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win_rise && !eval |=> !warn_flag && !soft_band && !hard_trip);

  // R7: both average channels finish together
  p_done_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_a[0] == done_a[1]);

endmodule

// File: tb/vswr_trip_det_tb.sv
module vswr_trip_det_tb;

  localparam int PW = 16;
  localparam int TW = 8;
  localparam int RW = 8;
  localparam int PCW = 8;
  localparam int MAXS = 4096;
  localparam int NV = 11;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           calc_win = 1'b0;
  logic           smp_valid = 1'b0;
  logic [PW-1:0]  fwd_pwr = '0;
  logic [PW-1:0]  rev_pwr = '0;
  logic [TW-1:0]  warn_thr = 8'd3;
  logic [TW-1:0]  soft_thr = 8'd13;
  logic [TW-1:0]  hard_thr = 8'd51;
  logic [PW-1:0]  min_fwd = 16'd100;
  logic [RW-1:0]  run_len = '0;
  logic [PCW-1:0] pulse_lim = '0;
  logic           warn_flag, soft_band, soft_trip, hard_trip, avg_done;
  logic [PW-1:0]  avg_fwd, avg_rev;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  vswr_trip_det #(.PW(PW), .TW(TW), .RW(RW), .PCW(PCW), .MAX_SAMPLES(MAXS)) u_dut (
    .clk(clk), .rst_n(rst_n), .calc_win(calc_win), .smp_valid(smp_valid),
    .fwd_pwr(fwd_pwr), .rev_pwr(rev_pwr), .warn_thr(warn_thr), .soft_thr(soft_thr),
    .hard_thr(hard_thr), .min_fwd(min_fwd), .run_len(run_len), .pulse_lim(pulse_lim),
    .warn_flag(warn_flag), .soft_band(soft_band), .soft_trip(soft_trip),
    .hard_trip(hard_trip), .avg_fwd(avg_fwd), .avg_rev(avg_rev), .avg_done(avg_done)
  );

  // {fwd, rev, level}; level 0 normal, 1 warning, 2 soft, 3 hard
  // limits 3/256, 13/256, 51/256; floor 100
  localparam logic [33:0] VEC [NV] = '{
    {16'd1000,  16'd5,     2'd0},
    {16'd1000,  16'd12,    2'd1},
    {16'd1000,  16'd11,    2'd0},
    {16'd1000,  16'd50,    2'd1},
    {16'd1000,  16'd51,    2'd2},
    {16'd1000,  16'd199,   2'd2},
    {16'd1000,  16'd200,   2'd3},
    {16'd60000, 16'd30000, 2'd3},
    {16'd65535, 16'd0,     2'd0},
    {16'd200,   16'd100,   2'd3},
    {16'd99,    16'd99,    2'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic open_win();
    @(negedge clk);
    calc_win = 1'b1;
  endtask

  task automatic sample(input logic [PW-1:0] f, input logic [PW-1:0] r);
    @(negedge clk);
    smp_valid = 1'b1;
    fwd_pwr = f;
    rev_pwr = r;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic close_win();
    int n;
    @(negedge clk);
    calc_win = 1'b0;
    n = 0;
    while (!avg_done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk("R7 done strobe seen", 32'(avg_done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset flags", 32'({warn_flag, soft_band, soft_trip, hard_trip, avg_done}), 0);
    chk("R8 reset avg", 32'({avg_fwd, avg_rev}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: hard-ratio sample outside the window is ignored
    sample(16'd1000, 16'd900);
    @(negedge clk);
    chk("R3 outside window hard", 32'(hard_trip), 0);
    chk("R3 outside window warn", 32'(warn_flag), 0);

    // R1 / R2 / R3 / R7 table walk, one window per vector
    for (int i = 0; i < NV; i++) begin
      logic [15:0] f;
      logic [15:0] r;
      logic [1:0]  lv;
      f = VEC[i][33:18];
      r = VEC[i][17:2];
      lv = VEC[i][1:0];
      open_win();
      sample(f, r);
      chk($sformatf("R1 warn vec%0d", i), 32'(warn_flag), 32'(lv == 2'd1));
      chk($sformatf("R1 soft band vec%0d", i), 32'(soft_band), 32'(lv == 2'd2));
      chk($sformatf("R2 hard vec%0d", i), 32'(hard_trip), 32'(lv == 2'd3));
      close_win();
      chk($sformatf("R7 avg fwd vec%0d", i), 32'(avg_fwd), 32'(f));
      chk($sformatf("R7 avg rev vec%0d", i), 32'(avg_rev), 32'(r));
      @(negedge clk);
      chk("R7 done one cycle", 32'(avg_done), 0);
    end

    // R2 hold after close, R9 clear on open
    open_win();
    sample(16'd1000, 16'd500);
    close_win();
    chk("R2 hard held past close", 32'(hard_trip), 1);
    open_win();
    @(negedge clk);
    chk("R9 open clears hard", 32'(hard_trip), 0);
    close_win();

    // R4 run persistence, run_len 3
    run_len = 8'd3;
    open_win();
    sample(16'd1000, 16'd60);
    sample(16'd1000, 16'd60);
    sample(16'd1000, 16'd20);
    sample(16'd1000, 16'd60);
    sample(16'd50,   16'd40);
    sample(16'd1000, 16'd300);
    chk("R4 two in run after restart", 32'(soft_trip), 0);
    sample(16'd1000, 16'd60);
    chk("R4 third in run trips", 32'(soft_trip), 1);
    close_win();
    chk("R6 soft held after in-band window", 32'(soft_trip), 1);
    open_win();
    sample(16'd1000, 16'd5);
    close_win();
    chk("R6 clean window clears soft", 32'(soft_trip), 0);

    // R5 pulse recurrence, pulse_lim 3
    run_len = 8'd0;
    pulse_lim = 8'd3;
    for (int k = 0; k < 3; k++) begin
      open_win();
      sample(16'd1000, 16'd100);
      close_win();
      chk($sformatf("R5 window %0d", k + 1), 32'(soft_trip), 32'(k == 2));
    end
    open_win();
    sample(16'd1000, 16'd5);
    close_win();
    chk("R6 clear after recurrence", 32'(soft_trip), 0);
    for (int k = 0; k < 2; k++) begin
      open_win();
      sample(16'd1000, 16'd100);
      close_win();
    end
    open_win();
    sample(16'd1000, 16'd20);
    close_win();
    open_win();
    sample(16'd1000, 16'd100);
    close_win();
    chk("R5 count restarted by clean window", 32'(soft_trip), 0);
    pulse_lim = 8'd0;

    // R7 mixed window, ungraded samples included
    open_win();
    sample(16'd10, 16'd1);
    sample(16'd20, 16'd2);
    sample(16'd30, 16'd3);
    sample(16'd40, 16'd4);
    sample(16'd45, 16'd6);
    close_win();
    chk("R7 mixed avg fwd", 32'(avg_fwd), 29);
    chk("R7 mixed avg rev", 32'(avg_rev), 3);

    // R7 empty window
    open_win();
    close_win();
    chk("R7 empty avg fwd", 32'(avg_fwd), 0);
    chk("R7 empty avg rev", 32'(avg_rev), 0);

    // R7 sample cap
    open_win();
    for (int k = 0; k < MAXS; k++) sample(16'd1000, 16'd7);
    for (int k = 0; k < 4; k++) sample(16'd0, 16'd0);
    close_win();
    chk("R7 capped avg fwd", 32'(avg_fwd), 1000);
    chk("R7 capped avg rev", 32'(avg_rev), 7);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule